// File: doc/BRIEF.md
# Status-Coded I2C Slave Engine

This block is a byte-level I2C slave that sits between the open-drain SCL/SDA pins and a host processor. It synchronises both lines and detects START and STOP. It shifts serial bits in and out and compares each address byte with a programmable 7-bit address. It can also compare against the general-call address (0x00) when that is enabled. A host-held acknowledge-enable level (`aa`) decides whether the engine takes part on the bus at all. It also decides whether each received byte is acknowledged.

Each meaningful bus event moves the engine to a numbered state. On entry it publishes an 8-bit status code, raises the interrupt flag `si`, and stretches the SCL low phase until the host writes `si_clr`. The host reads the status code, supplies the next byte to send or collects the received one, adjusts `aa`, and then clears the flag to let the transfer continue. Receive and transmit slave roles are both covered. Master operation is not part of this block.

Top module: `i2c_status_slave`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) `status` reads 0xF8, `si` is 0, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: `status[2:0]` always reads 000, and `status[7:3]` carries the state code. 0xF8 means no information, and entering it never raises `si`.
- R3: Entering any state other than 0xF8 sets `si` in the same cycle as the new code.
- R4: While `si` is 1 and SCL is seen low, the engine drives SCL low (`scl_oe`=1). It never starts pulling SCL low while SCL is high, so an `si` raised by a STOP leaves SCL high.
- R5: Only a host pulse on `si_clr` clears `si`. Clearing it releases SCL.
- R6: With `aa`=1, an address byte whose upper seven bits equal `own_addr` is acknowledged (SDA low in the ninth clock). It then enters 0x60 when bit 0 (R/W) is 0, or 0xA8 when that bit is 1.
- R7: With `aa`=1 and `gc_en`=1, the address byte 0x00 is acknowledged and enters 0x70. Data bytes that follow enter 0x90 (acknowledged) or 0x98 (not acknowledged). With `gc_en`=0, address 0x00 gets no acknowledge and no `si`.
- R8: While addressed as a receiver, a data byte is acknowledged when `aa`=1 and enters 0x80. When `aa`=0 it is left unacknowledged and enters 0x88, and the engine becomes not-addressed. The byte appears on `rx_byte`, MSB received first.
- R9: When not addressed, or when `aa`=0 at the address decision, the engine sends no acknowledge and raises no `si`. This applies to its own address and to the general-call address.
- R10: `aa` is sampled at the end of the address byte, so setting it part-way through an address byte still leads to recognition.
- R11: In 0xA8 and 0xB8, clearing `si` loads `tx_byte`, which is sent MSB first, and latches `aa`=0 as "last byte". After the master's acknowledge slot the engine enters 0xB8 (acknowledged), 0xC0 (not acknowledged) or 0xC8 (last byte, acknowledged). From 0xC0 or 0xC8 SDA stays released and the engine is not-addressed.
- R12: A STOP or a repeated START while addressed as a receiver enters 0xA0. After a repeated START the following address byte is matched again.
- R13: The status code remains on `status` in the cycle after `si` is cleared, and reads 0xF8 from the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | 7 | Slave address to respond to |
| gc_en | input | 1 | Respond to the general-call address |
| aa | input | 1 | Acknowledge enable from the host |
| si_clr | input | 1 | Host pulse that clears the interrupt flag |
| si | output | 1 | Interrupt flag |
| status | output | 8 | State code, low three bits zero |
| rx_byte | output | 8 | Last data byte received |
| tx_byte | input | 8 | Byte to send, loaded when `si` is cleared in 0xA8/0xB8 |

## Verification
The bench raises `aa` in the middle of an address byte. A design that samples `aa` at the START would then ignore its own address. It also ends a read with a last byte and with a master not-acknowledge. A design that keeps driving SDA after 0xC8 or 0xC0 would corrupt the bytes the master clocks afterwards, and the bench would see 0xFF replaced by data. It also checks that SCL stays high while the 0xA0 raised by a STOP is pending, which an engine that stretches unconditionally would fail. The status word is checked in the exact cycle after `si` is cleared, and random write transfers with random addresses, `aa` and `gc_en` settings test the acknowledge decisions against a model.

// File: rtl/i2c_ss_pkg.sv
// Shared types and state codes for the status-coded I2C slave engine.
// Codes are the upper five bits of the status byte; the low three read zero.
package i2c_ss_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CODE_W = BYTE_W - 3;

    // Engine phase within a transfer
    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_AACK, PH_RXD, PH_RACK, PH_TXD, PH_TACK
    } phase_t;

    localparam logic [CODE_W-1:0] ST_NONE     = 5'h1F; // F8
    localparam logic [CODE_W-1:0] ST_W_ACK    = 5'h0C; // 60
    localparam logic [CODE_W-1:0] ST_GC_ACK   = 5'h0E; // 70
    localparam logic [CODE_W-1:0] ST_RX_ACK   = 5'h10; // 80
    localparam logic [CODE_W-1:0] ST_RX_NACK  = 5'h11; // 88
    localparam logic [CODE_W-1:0] ST_GRX_ACK  = 5'h12; // 90
    localparam logic [CODE_W-1:0] ST_GRX_NACK = 5'h13; // 98
    localparam logic [CODE_W-1:0] ST_STOP     = 5'h14; // A0
    localparam logic [CODE_W-1:0] ST_R_ACK    = 5'h15; // A8
    localparam logic [CODE_W-1:0] ST_TX_ACK   = 5'h17; // B8
    localparam logic [CODE_W-1:0] ST_TX_NACK  = 5'h18; // C0
    localparam logic [CODE_W-1:0] ST_TX_LAST  = 5'h19; // C8
endpackage

// File: rtl/i2c_ss_lines.sv
// Line conditioner: synchronises SCL and SDA through STAGES flops and
// reports SCL edges plus START/STOP conditions as one-cycle pulses.
// Assumes the system clock is at least 20x the SCL rate.
module i2c_ss_lines #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_sh, sda_sh;
    logic          scl_p, sda_p;

    // Synchroniser chains plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[LAST-1:0], scl_i};
            sda_sh <= {sda_sh[LAST-1:0], sda_i};
            scl_p  <= scl_sh[LAST];
            sda_p  <= sda_sh[LAST];
        end
    end

    assign scl_s     = scl_sh[LAST];
    assign sda_s     = sda_sh[LAST];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ss_match.sv
// Address comparator: flags an own-address or general-call hit for the
// byte just shifted in, gated by the acknowledge-enable level.
module i2c_ss_match
    import i2c_ss_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              aa,
    output logic              own_hit,
    output logic              gc_hit
);
    // Pure compare; the R/W bit is bit 0 of the byte
    always_comb begin
        own_hit = aa && (addr_byte[BYTE_W-1:1] == own_addr);
        gc_hit  = aa && gc_en && (addr_byte == '0);
    end
endmodule

// File: rtl/i2c_status_slave.sv
// Status-coded I2C slave engine (top). Walks the slave receive/transmit
// states, publishes a code per event, raises si and stretches SCL low
// until the host pulses si_clr. Assumes clk >= 20x SCL.
module i2c_status_slave
    import i2c_ss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              aa,
    input  logic              si_clr,
    output logic              si,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] tx_byte
);
    localparam logic [3:0] BITS = 4'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic own_hit, gc_hit;

    phase_t            phase;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, rx_q;
    logic [CODE_W-1:0] code_q;
    logic si_q, sda_q, rw_q, gc_q, last_q, mack_q, acked_q, load_pend, clr_d;
    logic scl_hold_q;
    logic in_rx;

    i2c_ss_lines #(.STAGES(SYNC_STAGES)) u_lines (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_ss_match u_match (
        .addr_byte(rx_sh), .own_addr(own_addr), .gc_en(gc_en), .aa(aa),
        .own_hit(own_hit), .gc_hit(gc_hit)
    );

    assign in_rx = (phase == PH_RXD) || (phase == PH_RACK);

    // Receive shifter: samples SDA on every SCL rise, addressed or not
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sh <= '0;
        else if (scl_rise) rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
    end

    // Clock stretch: latch a hold once SCL is seen low while si is set
    always_ff @(posedge clk) begin
        if (!rst_n) scl_hold_q <= 1'b0;
        else        scl_hold_q <= si_q & (scl_hold_q | ~scl_s);
    end

    // Main engine: host clear actions, bus conditions, then per-phase bit work
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            tx_sh     <= '0;
            rx_q      <= '0;
            code_q    <= ST_NONE;
            si_q      <= 1'b0;
            sda_q     <= 1'b0;
            rw_q      <= 1'b0;
            gc_q      <= 1'b0;
            last_q    <= 1'b0;
            mack_q    <= 1'b0;
            acked_q   <= 1'b0;
            load_pend <= 1'b0;
            clr_d     <= 1'b0;
        end else begin
            clr_d <= 1'b0;
            if (clr_d) code_q <= ST_NONE;
            if (si_clr && si_q) begin
                si_q  <= 1'b0;
                clr_d <= 1'b1;
                if (load_pend) begin
                    tx_sh     <= tx_byte;
                    sda_q     <= ~tx_byte[BYTE_W-1];
                    last_q    <= ~aa;
                    bit_cnt   <= '0;
                    load_pend <= 1'b0;
                end
            end
            if (start_det) begin
                if (in_rx) begin si_q <= 1'b1; code_q <= ST_STOP; end
                phase     <= PH_ADDR;
                bit_cnt   <= '0;
                sda_q     <= 1'b0;
                load_pend <= 1'b0;
            end else if (stop_det) begin
                if (in_rx) begin si_q <= 1'b1; code_q <= ST_STOP; end
                phase     <= PH_IDLE;
                sda_q     <= 1'b0;
                load_pend <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                        else if (scl_fall && bit_cnt == BITS) begin
                            if (own_hit || gc_hit) begin
                                sda_q <= 1'b1;
                                phase <= PH_AACK;
                                rw_q  <= rx_sh[0];
                                gc_q  <= ~own_hit;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_AACK: if (scl_fall) begin
                        sda_q   <= 1'b0;
                        bit_cnt <= '0;
                        si_q    <= 1'b1;
                        if (rw_q) begin
                            code_q    <= ST_R_ACK;
                            phase     <= PH_TXD;
                            load_pend <= 1'b1;
                        end else begin
                            code_q <= gc_q ? ST_GC_ACK : ST_W_ACK;
                            phase  <= PH_RXD;
                        end
                    end
                    PH_RXD: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                        else if (scl_fall && bit_cnt == BITS) begin
                            rx_q    <= rx_sh;
                            sda_q   <= aa;
                            acked_q <= aa;
                            phase   <= PH_RACK;
                        end
                    end
                    PH_RACK: if (scl_fall) begin
                        sda_q   <= 1'b0;
                        bit_cnt <= '0;
                        si_q    <= 1'b1;
                        if (acked_q) begin
                            code_q <= gc_q ? ST_GRX_ACK : ST_RX_ACK;
                            phase  <= PH_RXD;
                        end else begin
                            code_q <= gc_q ? ST_GRX_NACK : ST_RX_NACK;
                            phase  <= PH_IDLE;
                        end
                    end
                    PH_TXD: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                        else if (scl_fall && bit_cnt == BITS) begin
                            sda_q <= 1'b0;
                            phase <= PH_TACK;
                        end else if (scl_fall && bit_cnt != '0) begin
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_q <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    PH_TACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        else if (scl_fall) begin
                            bit_cnt <= '0;
                            si_q    <= 1'b1;
                            if (!mack_q) begin
                                code_q <= ST_TX_NACK;
                                phase  <= PH_IDLE;
                            end else if (last_q) begin
                                code_q <= ST_TX_LAST;
                                phase  <= PH_IDLE;
                            end else begin
                                code_q    <= ST_TX_ACK;
                                phase     <= PH_TXD;
                                load_pend <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_oe  = si_q & scl_hold_q;
    assign sda_oe  = sda_q;
    assign si      = si_q;
    assign status  = {code_q, 3'b000};
    assign rx_byte = rx_q;

    // R3: a raised flag always comes with a real state code
    a_r3_entry_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si_q) |-> code_q != ST_NONE);
    // R5: the flag is sticky until the host clears it
    a_r5_host_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        si_q && !si_clr |=> si_q);
    // R13: the code is still present when the flag drops
    a_r13_code_outlives_si: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(si_q) |-> code_q != ST_NONE);
    // R4: stretching follows a low SCL seen while the flag was up
    a_r4_hold_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        si_q && $past(si_q) && !$past(scl_s) |-> scl_oe);
    // R4: a high SCL is never newly pulled low
    a_r4_high_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl_s) && !$past(scl_hold_q) |-> !scl_oe);
    // R9: a not-addressed engine leaves SDA alone
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_IDLE && $past(phase == PH_IDLE) |-> !sda_oe);
    // R8: a not-acknowledged byte drops the engine to not-addressed
    a_r8_nack_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si_q) && code_q == ST_RX_NACK |-> phase == PH_IDLE);
    // R11: the master owns SDA in its acknowledge slot
    a_r11_master_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_TACK |-> !sda_oe);
endmodule

// File: tb/tb_i2c_status_slave.sv
// Bench: bus master model plus host model, directed corners and seeded
// random write transfers checked against a bench-side expectation.
module tb_i2c_status_slave;
    localparam logic [6:0] OWN = 7'h2A;
    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_w, sda_w;
    logic scl_oe, sda_oe, si;
    logic [6:0] own_addr = OWN;
    logic gc_en = 1'b0, aa = 1'b0, si_clr = 1'b0;
    logic [7:0] status, rx_byte, tx_byte = 8'h00;
    int vectors = 0, miscompares = 0;

    always #2 clk = ~clk;

    assign scl_w = scl_m & ~scl_oe;
    assign sda_w = sda_m & ~sda_oe;

    i2c_status_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en),
        .aa(aa), .si_clr(si_clr), .si(si), .status(status),
        .rx_byte(rx_byte), .tx_byte(tx_byte)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_ack(input logic [6:0] a, input bit aa_v, input bit ge);
        return aa_v && ((a == OWN) || (ge && a == 7'h00));
    endfunction

    function automatic logic [7:0] exp_rx_code(input bit acked, input bit gcf);
        if (gcf) return acked ? 8'h90 : 8'h98;
        return acked ? 8'h80 : 8'h88;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mbit(input logic b, output logic got);
        sda_m = b;
        wait_cyc(Q);
        scl_m = 1'b1;
        while (!scl_w) @(negedge clk);
        wait_cyc(Q);
        got = sda_w;
        wait_cyc(Q);
        scl_m = 1'b0;
        wait_cyc(Q);
    endtask

    task automatic mstart();
        sda_m = 1'b1;
        wait_cyc(Q);
        scl_m = 1'b1;
        while (!scl_w) @(negedge clk);
        wait_cyc(Q);
        sda_m = 1'b0;
        wait_cyc(Q);
        scl_m = 1'b0;
        wait_cyc(Q);
    endtask

    task automatic mstop();
        sda_m = 1'b0;
        wait_cyc(Q);
        scl_m = 1'b1;
        while (!scl_w) @(negedge clk);
        wait_cyc(Q);
        sda_m = 1'b1;
        wait_cyc(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic g;
        for (int i = 7; i >= 0; i--) mbit(v[i], g);
        mbit(1'b1, g);
        acked = !g;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            mbit(1'b1, g);
            v[i] = g;
        end
        mbit(mack ? 1'b0 : 1'b1, g);
    endtask

    task automatic no_si(input string req);
        bit seen = 0;
        for (int i = 0; i < 80; i++) begin
            if (si) seen = 1;
            @(negedge clk);
        end
        chk(req, seen, 0);
    endtask

    // Host: await flag, check code and stretch, set inputs, clear
    task automatic service(input string req, input logic [7:0] code, input bit in_low,
                           input logic [7:0] tx, input bit aa_v);
        bit got = 0;
        for (int i = 0; i < 150 && !got; i++) begin
            if (si) got = 1;
            else @(negedge clk);
        end
        chk(req, got, 1);
        chk(req, status, code);
        chk("R2 low bits", status[2:0], 0);
        if (in_low) begin
            wait_cyc(4);
            scl_m = 1'b1;
            wait_cyc(10);
            chk("R4 stretch", scl_w, 0);
            scl_m = 1'b0;
        end else begin
            wait_cyc(10);
            chk("R4 high kept", scl_w, 1);
        end
        chk("R5 sticky", si, 1);
        tx_byte = tx;
        aa = aa_v;
        @(negedge clk) si_clr = 1'b1;
        @(negedge clk) si_clr = 1'b0;
        chk("R5 cleared", si, 0);
        chk("R13 kept", status, code);
        @(negedge clk);
        chk("R13 to F8", status, 8'hF8);
    endtask

    initial begin
        repeat (1) @(posedge clk);
        repeat (180000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        bit ack;
        logic g;
        logic [7:0] v;
        void'($urandom(32'h5EED1234));
        wait_cyc(6);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        chk("R1 status", status, 8'hF8);
        chk("R1 si", si, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);

        // R6/R8 write: address, acked byte, nacked byte, then ignored byte
        aa = 1;
        mstart();
        send_byte({OWN, 1'b0}, ack);
        chk("R6 addr ack", ack, 1);
        service("R6 code 60", 8'h60, 1, 8'h00, 1);
        send_byte(8'hA5, ack);
        chk("R8 data ack", ack, 1);
        service("R8 code 80", 8'h80, 1, 8'h00, 0);
        chk("R8 rx_byte", rx_byte, 8'hA5);
        send_byte(8'h3C, ack);
        chk("R8 data nack", ack, 0);
        service("R8 code 88", 8'h88, 1, 8'h00, 1);
        chk("R8 rx_byte nack", rx_byte, 8'h3C);
        send_byte(8'h77, ack);
        chk("R9 no ack after 88", ack, 0);
        no_si("R9 no si after 88");
        mstop();
        no_si("R9 no si on stop");

        // R9 own address with aa clear
        aa = 0;
        mstart();
        send_byte({OWN, 1'b0}, ack);
        chk("R9 aa clear nack", ack, 0);
        no_si("R9 aa clear no si");
        mstop();

        // R10 aa raised mid-address; R12 STOP after addressing
        mstart();
        for (int i = 7; i >= 4; i--) mbit(OWN[i-1], g);
        aa = 1;
        for (int i = 3; i >= 1; i--) mbit(OWN[i-1], g);
        mbit(1'b0, g);
        mbit(1'b1, g);
        chk("R10 late aa ack", g, 0);
        service("R10 code 60", 8'h60, 1, 8'h00, 1);
        mstop();
        service("R12 stop A0", 8'hA0, 0, 8'h00, 1);

        // R12 repeated start while receiving, then re-address
        mstart();
        send_byte({OWN, 1'b0}, ack);
        service("R12 code 60", 8'h60, 1, 8'h00, 1);
        send_byte(8'h5A, ack);
        service("R12 code 80", 8'h80, 1, 8'h00, 1);
        mstart();
        service("R12 rstart A0", 8'hA0, 1, 8'h00, 1);
        send_byte({OWN, 1'b0}, ack);
        chk("R12 readdress ack", ack, 1);
        service("R12 code 60 again", 8'h60, 1, 8'h00, 1);
        mstop();
        service("R12 stop A0 2", 8'hA0, 0, 8'h00, 1);

        // R7 general call enabled and disabled
        gc_en = 1;
        mstart();
        send_byte(8'h00, ack);
        chk("R7 gc ack", ack, 1);
        service("R7 code 70", 8'h70, 1, 8'h00, 1);
        send_byte(8'hC3, ack);
        chk("R7 gc data ack", ack, 1);
        service("R7 code 90", 8'h90, 1, 8'h00, 1);
        chk("R7 gc rx_byte", rx_byte, 8'hC3);
        mstop();
        service("R7 stop A0", 8'hA0, 0, 8'h00, 1);
        gc_en = 0;
        mstart();
        send_byte(8'h00, ack);
        chk("R7 gc off nack", ack, 0);
        no_si("R7 gc off no si");
        mstop();

        // R11 read: B8, last byte C8, released SDA afterwards
        mstart();
        send_byte({OWN, 1'b1}, ack);
        chk("R6 read ack", ack, 1);
        service("R6 code A8", 8'hA8, 1, 8'h96, 1);
        recv_byte(1, v);
        chk("R11 byte 1", v, 8'h96);
        service("R11 code B8", 8'hB8, 1, 8'h4D, 0);
        recv_byte(1, v);
        chk("R11 last byte", v, 8'h4D);
        service("R11 code C8", 8'hC8, 1, 8'h00, 1);
        recv_byte(0, v);
        chk("R11 released after C8", v, 8'hFF);
        no_si("R11 no si after C8");
        mstop();

        // R11 read ended by master nack: C0
        mstart();
        send_byte({OWN, 1'b1}, ack);
        service("R6 code A8 2", 8'hA8, 1, 8'h21, 1);
        recv_byte(0, v);
        chk("R11 byte nack", v, 8'h21);
        service("R11 code C0", 8'hC0, 1, 8'h00, 1);
        recv_byte(0, v);
        chk("R11 released after C0", v, 8'hFF);
        mstop();
        no_si("R11 no si after C0 stop");

        // Random write transfers against the bench model
        for (int t = 0; t < 14; t++) begin
            logic [6:0] a;
            bit aa_a, ge, e, addressed, gcf;
            a    = ($urandom % 2) ? OWN : (($urandom % 4 == 0) ? 7'h00 : 7'($urandom));
            aa_a = ($urandom % 4) != 0;
            ge   = $urandom % 2;
            aa = aa_a;
            gc_en = ge;
            mstart();
            send_byte({a, 1'b0}, ack);
            e = exp_ack(a, aa_a, ge);
            chk(e ? "R6 rnd addr" : "R9 rnd addr", ack, e);
            addressed = e;
            gcf = (a != OWN);
            if (e) begin
                service(gcf ? "R7 rnd 70" : "R6 rnd 60", gcf ? 8'h70 : 8'h60, 1, 8'h00, 1);
                for (int n = 0; n < 1 + int'($urandom % 3) && addressed; n++) begin
                    bit a2;
                    logic [7:0] d;
                    a2 = ($urandom % 3) != 0;
                    d = 8'($urandom);
                    aa = a2;
                    send_byte(d, ack);
                    chk("R8 rnd ack", ack, a2);
                    service("R8 rnd code", exp_rx_code(a2, gcf), 1, 8'h00, 1);
                    chk("R8 rnd rx", rx_byte, d);
                    addressed = a2;
                end
            end else begin
                no_si("R9 rnd no si");
            end
            mstop();
            if (addressed) service("R12 rnd A0", 8'hA0, 0, 8'h00, 1);
            else no_si("R9 rnd stop");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule